// File: doc/BRIEF.md
# Three-Clock Gated Frequency Counter

This block compares the rates of three unrelated clocks: the clock recovered by a serial receiver, the local system clock and an auxiliary helper clock. A single enable level, driven from the system-clock register domain, opens a common measurement window. Each clock counts its own rising edges inside that window through a divide-by-four prescaler, so a window of 2^24 system-clock periods yields counts near 2^22. The enable reaches every counting domain through a two-stage synchronizer, so each window is seen by all three counters.

When the enable drops, each counting domain freezes its count in a holding register and flips a toggle. The toggle is synchronized back into the system domain, where the stable held value is copied into a result register. The copy cannot be torn because the held value does not change while the handoff is in flight. A completion flag rises once all three results have arrived. The block also reports, in the system domain, the signed difference between the recovered-clock count and the system-clock count, and that difference scaled into an oscillator-offset figure by a fixed-point factor of about 2048.26.

Software raises the enable, waits for the window length it wants, lowers the enable, polls the completion flag and then reads the counts and the derived offset.

Top module: `fc_top`

## Requirements
- R1: After reset, all three counts, the difference and the offset read zero, and the completion flag is low.
- R2: Each channel reports floor(E/4), where E is the number of rising edges of its own clock at which the enable is sampled high. A window with fewer than four edges reports zero.
- R3: Each window counts from zero. No part of an earlier window's count carries into the next result.
- R4: The reported counts change only when a window completes. They keep the previous window's values while a new window is open and for as long as no window ends.
- R5: The completion flag is low in the cycle after any system-clock edge that samples the enable high. It rises only after the enable has fallen and all three channels have delivered their counts.
- R6: The difference output equals the recovered-clock count minus the system-clock count, as a signed value one bit wider than a count.
- R7: The offset output equals floor(difference × 524355 / 256), a signed value. Its sign follows the sign of the difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock: register domain and second counted clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| clk_rx | input | 1 | Recovered receiver clock, first counted clock |
| clk_hlp | input | 1 | Helper clock, third counted clock |
| upd_en_i | input | 1 | Measurement window enable, system-clock domain |
| rx_count_o | output | CNT_W | Last completed count of the recovered clock |
| sys_count_o | output | CNT_W | Last completed count of the system clock |
| hlp_count_o | output | CNT_W | Last completed count of the helper clock |
| done_o | output | 1 | All three counts delivered since the enable fell |
| delta_o | output | CNT_W+1 | Signed recovered count minus system count |
| offset_o | output | CNT_W+SCALE_W+1-FRAC_W | Signed scaled frequency offset |

## Verification
The hardest situation to reach is a negative difference, where the recovered clock runs slower than the system clock, combined with a result that must stay frozen while a newer window is still open. The bench changes the recovered and helper clock periods between windows, so the same block sees faster, slower and mixed rates. It samples the outputs halfway through each new window to confirm that the old values persist and that the completion flag is low. The enable always moves at instants that fall between the edges of all three clocks, so the bench can count the sampled edges of each clock exactly and predict every count without tolerance.

// File: rtl/fc_pkg.sv
`timescale 1ns/100ps
package fc_pkg;
  localparam int NUM_CH = 3;
  typedef enum int {
    CH_RX  = 0,
    CH_SYS = 1,
    CH_HLP = 2
  } ch_idx_e;
endpackage

// File: rtl/fc_sync2.sv
`timescale 1ns/100ps
// Two-stage synchronizer into the domain of clk.
module fc_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/fc_rst_sync.sv
`timescale 1ns/100ps
// Reset goes active at once and is released on a clock edge.
module fc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_n_o = chain_q[1];
endmodule

// File: rtl/fc_channel.sv
`timescale 1ns/100ps
// One counting domain: enable sync, prescaler, counter, freeze and toggle.
module fc_channel #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 2
) (
  input  logic             clk_i,
  input  logic             arst_n,
  input  logic             en_async_i,
  output logic [CNT_W-1:0] hold_o,
  output logic             tgl_o
);
  localparam logic [PRE_W-1:0] PRE_LAST  = '1;
  localparam logic [PRE_W-1:0] PRE_FIRST = PRE_W'(1);

  logic             rst_n;
  logic             en_s;
  logic             en_q;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic             tgl_q, tgl_d;
  logic             start, stop;

  fc_rst_sync u_rst (
    .clk     (clk_i),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  fc_sync2 #(.W(1)) u_en_sync (
    .clk   (clk_i),
    .rst_n (rst_n),
    .d     (en_async_i),
    .q     (en_s)
  );

  assign start = en_s & ~en_q;
  assign stop  = ~en_s & en_q;

  always_comb begin
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    tgl_d  = tgl_q;
    if (start) begin
      pre_d = PRE_FIRST;
      cnt_d = '0;
    end else if (en_s) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        cnt_d = cnt_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
    if (stop) begin
      hold_d = cnt_q;
      tgl_d  = ~tgl_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      en_q   <= en_s;
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      tgl_q  <= tgl_d;
    end
  end

  assign hold_o = hold_q;
  assign tgl_o  = tgl_q;

  // R2: outside a window the running count does not move
  p_idle_count_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!en_s && !en_q) |=> $stable(cnt_q));

  // R4: the frozen value only changes at the close of a window
  p_hold_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !stop |=> $stable(hold_q));

  // R4: each close of a window is announced by exactly one toggle flip
  p_toggle_on_close_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    stop |=> (tgl_q != $past(tgl_q)));
endmodule

// File: rtl/fc_top.sv
`timescale 1ns/100ps
module fc_top #(
  parameter int CNT_W   = 24,
  parameter int PRE_W   = 2,
  parameter int SCALE_W = 21,
  parameter int SCALE_Q = 524355,
  parameter int FRAC_W  = 8
) (
  input  logic                                 clk_sys,
  input  logic                                 rst_n,
  input  logic                                 clk_rx,
  input  logic                                 clk_hlp,
  input  logic                                 upd_en_i,
  output logic [CNT_W-1:0]                     rx_count_o,
  output logic [CNT_W-1:0]                     sys_count_o,
  output logic [CNT_W-1:0]                     hlp_count_o,
  output logic                                 done_o,
  output logic signed [CNT_W:0]                delta_o,
  output logic signed [CNT_W+SCALE_W-FRAC_W:0] offset_o
);
  import fc_pkg::*;

  localparam int DIFF_W = CNT_W + 1;
  localparam int PROD_W = DIFF_W + SCALE_W;
  localparam logic signed [SCALE_W-1:0] SCALE_S = SCALE_W'(SCALE_Q);

  logic               rst_sys_n;
  logic [NUM_CH-1:0]  clk_vec;
  logic [CNT_W-1:0]   hold   [NUM_CH];
  logic [NUM_CH-1:0]  tgl;
  logic [NUM_CH-1:0]  tgl_s;
  logic [NUM_CH-1:0]  tgl_q;
  logic [NUM_CH-1:0]  cap;
  logic [NUM_CH-1:0]  ack_q, ack_d;
  logic [CNT_W-1:0]   res_q  [NUM_CH];
  logic [CNT_W-1:0]   res_d  [NUM_CH];
  logic signed [DIFF_W-1:0] delta;
  logic signed [PROD_W-1:0] prod;

  assign clk_vec[CH_RX]  = clk_rx;
  assign clk_vec[CH_SYS] = clk_sys;
  assign clk_vec[CH_HLP] = clk_hlp;

  fc_rst_sync u_rst_sys (
    .clk     (clk_sys),
    .arst_n  (rst_n),
    .rst_n_o (rst_sys_n)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    fc_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
      .clk_i      (clk_vec[g]),
      .arst_n     (rst_n),
      .en_async_i (upd_en_i),
      .hold_o     (hold[g]),
      .tgl_o      (tgl[g])
    );

    fc_sync2 #(.W(1)) u_tgl_sync (
      .clk   (clk_sys),
      .rst_n (rst_sys_n),
      .d     (tgl[g]),
      .q     (tgl_s[g])
    );
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      cap[i]   = tgl_s[i] ^ tgl_q[i];
      res_d[i] = cap[i] ? hold[i] : res_q[i];
      ack_d[i] = upd_en_i ? 1'b0 : (ack_q[i] | cap[i]);
    end
  end

  always_ff @(posedge clk_sys or negedge rst_sys_n) begin
    if (!rst_sys_n) begin
      tgl_q <= '0;
      ack_q <= '0;
      for (int i = 0; i < NUM_CH; i++) res_q[i] <= '0;
    end else begin
      tgl_q <= tgl_s;
      ack_q <= ack_d;
      for (int i = 0; i < NUM_CH; i++) res_q[i] <= res_d[i];
    end
  end

  assign delta = $signed({1'b0, res_q[CH_RX]}) - $signed({1'b0, res_q[CH_SYS]});
  assign prod  = delta * SCALE_S;

  assign rx_count_o  = res_q[CH_RX];
  assign sys_count_o = res_q[CH_SYS];
  assign hlp_count_o = res_q[CH_HLP];
  assign done_o      = &ack_q;
  assign delta_o     = delta;
  assign offset_o    = prod[PROD_W-1:FRAC_W];

  // R5: an open window clears the completion flag by the next cycle
  p_done_clear_r5: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    upd_en_i |=> !done_o);

  // R5: completion only rises from an edge that saw the window closed
  p_done_rise_r5: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    $rose(done_o) |-> !$past(upd_en_i));

  // R7: the offset carries the sign of the difference
  p_offset_pos_r7: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    (delta_o > 0) |-> (offset_o > 0));
  p_offset_neg_r7: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    (delta_o < 0) |-> (offset_o < 0));
endmodule

// File: tb/fc_top_tb_top.sv
`timescale 1ns/100ps
module fc_top_tb_top;
  localparam real CLK_PERIOD = 8.0;
  localparam int  CNT_W   = 24;
  localparam int  SCALE_W = 21;
  localparam int  FRAC_W  = 8;
  localparam int  OFS_W   = CNT_W + SCALE_W + 1 - FRAC_W;

  logic clk_sys = 1'b0;
  logic clk_rx  = 1'b0;
  logic clk_hlp = 1'b0;
  logic rst_n   = 1'b0;
  logic upd_en  = 1'b0;
  logic [CNT_W-1:0] rx_count, sys_count, hlp_count;
  logic             done;
  logic signed [CNT_W:0]     delta;
  logic signed [OFS_W-1:0]   offset;

  real half_rx  = 3.8;
  real half_hlp = 4.2;

  int n_rx, n_sys, n_hlp;
  int checks = 0;
  int fails  = 0;

  fc_top dut_i (
    .clk_sys     (clk_sys),
    .rst_n       (rst_n),
    .clk_rx      (clk_rx),
    .clk_hlp     (clk_hlp),
    .upd_en_i    (upd_en),
    .rx_count_o  (rx_count),
    .sys_count_o (sys_count),
    .hlp_count_o (hlp_count),
    .done_o      (done),
    .delta_o     (delta),
    .offset_o    (offset)
  );

  always #(CLK_PERIOD/2.0) clk_sys = ~clk_sys;
  always #(half_rx)        clk_rx  = ~clk_rx;
  always #(half_hlp)       clk_hlp = ~clk_hlp;

  // Edge tallies of the stimulus: the enable never moves on any clock edge.
  always @(posedge clk_rx)  if (upd_en) n_rx  = n_rx + 1;
  always @(posedge clk_sys) if (upd_en) n_sys = n_sys + 1;
  always @(posedge clk_hlp) if (upd_en) n_hlp = n_hlp + 1;

  task automatic check(input string req, input string what,
                       input longint actual, input longint expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check_results(input string tag);
    longint e_rx, e_sys, e_hlp, e_d;
    e_rx  = longint'(n_rx  / 4);
    e_sys = longint'(n_sys / 4);
    e_hlp = longint'(n_hlp / 4);
    e_d   = e_rx - e_sys;
    check("R2", {tag, " rx count"},  longint'(rx_count),  e_rx);
    check("R2", {tag, " sys count"}, longint'(sys_count), e_sys);
    check("R2", {tag, " hlp count"}, longint'(hlp_count), e_hlp);
    check("R5", {tag, " done set"},  longint'(done), 1);
    check("R6", {tag, " delta"},     longint'(delta), e_d);
    check("R7", {tag, " offset"},    longint'(offset), (e_d * 524355) >>> 8);
  endtask

  // Opens a window of cyc system periods, checks R4/R5 midway, then closes it.
  task automatic run_window(input int cyc);
    logic [CNT_W-1:0] p_rx, p_sys, p_hlp;
    p_rx = rx_count; p_sys = sys_count; p_hlp = hlp_count;
    n_rx = 0; n_sys = 0; n_hlp = 0;
    @(negedge clk_sys); #0.1 upd_en = 1'b1;
    if (cyc >= 4) begin
      repeat (cyc/2) @(negedge clk_sys);
      check("R5", "done low in window", longint'(done), 0);
      check("R4", "rx held in window",  longint'(rx_count),  longint'(p_rx));
      check("R4", "sys held in window", longint'(sys_count), longint'(p_sys));
      check("R4", "hlp held in window", longint'(hlp_count), longint'(p_hlp));
      repeat (cyc - cyc/2) @(negedge clk_sys);
    end else begin
      repeat (cyc) @(negedge clk_sys);
    end
    #0.1 upd_en = 1'b0;
    repeat (14) @(negedge clk_sys);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_sys);
    #0.1 rst_n = 1'b1;
    repeat (4) @(negedge clk_sys);
    check("R1", "rx count",  longint'(rx_count), 0);
    check("R1", "sys count", longint'(sys_count), 0);
    check("R1", "hlp count", longint'(hlp_count), 0);
    check("R1", "done",      longint'(done), 0);
    check("R1", "delta",     longint'(delta), 0);
    check("R1", "offset",    longint'(offset), 0);
  endtask

  task automatic t_fast_rx;
    half_rx = 3.8; half_hlp = 4.2;
    run_window(400);
    check_results("fast rx");
  endtask

  task automatic t_hold_idle;
    logic [CNT_W-1:0] a, b, c;
    a = rx_count; b = sys_count; c = hlp_count;
    repeat (300) @(negedge clk_sys);
    check("R4", "rx held idle",  longint'(rx_count),  longint'(a));
    check("R4", "sys held idle", longint'(sys_count), longint'(b));
    check("R4", "hlp held idle", longint'(hlp_count), longint'(c));
    check("R5", "done held idle", longint'(done), 1);
  endtask

  task automatic t_slow_rx_restart;
    half_rx = 4.6;
    repeat (3) @(negedge clk_sys);
    run_window(120);
    check_results("slow rx R3");
    check("R6", "negative delta", longint'(delta < 0), 1);
  endtask

  task automatic t_tiny_window;
    run_window(1);
    check_results("tiny R3");
    check("R2", "tiny rx zero", longint'(rx_count), 0);
  endtask

  task automatic t_mixed;
    half_rx = 3.6; half_hlp = 4.8;
    repeat (3) @(negedge clk_sys);
    run_window(1000);
    check_results("mixed");
    half_rx = 4.2; half_hlp = 3.4;
    repeat (3) @(negedge clk_sys);
    run_window(777);
    check_results("mixed2");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_fast_rx();
    t_hold_idle();
    t_slow_rx_restart();
    t_tiny_window();
    t_mixed();
    summary();
  end
endmodule